// File: doc/BRIEF.md
# Passive Serial FPGA Configuration Loader

This block sits on the host side of a link to an SRAM-based FPGA and loads a bitstream into it. After a start pulse it drives the target's active-low configuration request low for a programmable number of cycles and waits until the target's status line has been seen low. It then releases the request and waits for the status line to come back high. From that point it shifts bitstream bytes out on a configuration clock that it generates itself. A byte goes out either one bit per clock on a single data pin or a whole byte per clock on eight pins.

Bytes come in on a valid/ready stream, and the byte marked last ends the stream. When no byte is available, the configuration clock is held low for as long as needed and resumes later with no bit lost. After the last byte the controller keeps clocking for a bounded number of extra edges while it waits for the target's done line to go high. A status drop during transfer ends the sequence with an error, and so does a missing done. Whenever the block is not busy, every line to the target is driven to a fixed low level, except the request, which is held high.

Top module: `cfg_loader`

## Requirements
- R1: After reset and whenever `busy` is low, `tgtReqN` is 1 and `tgtClk` and all of `tgtData` are 0. Out of reset, `busy`, `cfgDone` and `cfgErr` are 0.
- R2: A `start` pulse in idle drives `tgtReqN` low for at least `reqMin` cycles (0 counts as 1). It stays low until the synchronized status line has been seen low.
- R3: No rising edge appears on `tgtClk` until `tgtReqN` is high and the synchronized status line reads high. Target inputs pass through two flip-flops.
- R4: `tgtData` changes only while `tgtClk` is low, never during a high phase.
- R5: Every high phase of `tgtClk` lasts exactly `clkHalf` system cycles (0 counts as 1), and every low phase lasts at least `clkHalf` cycles.
- R6: With `parMode`=0, each byte produces eight rising edges and sends its bits least significant first on `tgtData[0]`. `tgtData[7:1]` stays 0.
- R7: With `parMode`=1, each byte produces one rising edge and is presented whole on `tgtData[7:0]`.
- R8: While no input byte is valid and the current byte is fully sent, `tgtClk` stays low. Transfer resumes with no bit lost or repeated.
- R9: If the synchronized done line is high during the post-data clocking, the sequence ends with `cfgDone`=1, `cfgErr`=0 and `busy`=0.
- R10: If the synchronized status line goes low during transfer or post-data clocking, the sequence aborts with `cfgErr`=1 and `cfgDone`=0. The target outputs return to their idle levels.
- R11: If done has not gone high after `tailMax` extra rising edges following the last data edge, `cfgErr` is set. Exactly `tailMax` extra edges are produced.
- R12: One byte is consumed per cycle with `inValid` and `inReady` both high. The byte with `inLast` set is the final one, and `inReady` stays low after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a load sequence when idle |
| parMode | input | 1 | 0 = one data pin, 1 = eight data pins |
| clkHalf | input | DIV_W | Configuration clock half period in system cycles |
| reqMin | input | CNT_W | Minimum request-low duration in system cycles |
| tailMax | input | CNT_W | Extra clock edges allowed after the last byte |
| inData | input | 8 | Bitstream byte |
| inValid | input | 1 | Byte valid |
| inLast | input | 1 | Marks the final byte |
| inReady | output | 1 | Byte accepted this cycle |
| tgtStatus | input | 1 | Target status line (open-drain, high = ready) |
| tgtDoneIn | input | 1 | Target done line (open-drain) |
| tgtReqN | output | 1 | Active-low configuration request to target |
| tgtClk | output | 1 | Configuration clock |
| tgtData | output | 8 | Configuration data |
| busy | output | 1 | Sequence in progress |
| cfgDone | output | 1 | Last sequence completed successfully |
| cfgErr | output | 1 | Last sequence failed |

## Verification
The bench goes after the stall case with long gaps in the byte stream. A design that let the clock run on an empty shifter would show extra rising edges or would shift zeros into the captured stream. It holds the target's status line high while the request is low. A controller that released the request on its timer alone would start clocking into a target that never reset. It also counts clock edges after the last byte when done never comes, where an off-by-one tail counter gives one edge too many or too few. It drops the status line in mid-transfer to catch a design that keeps clocking or leaves the clock high after the abort.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_WAIT, S_XFER, S_TAIL, S_FIN
  } ldState_t;

  typedef struct packed {
    logic clear;    // wipe shifter at sequence start
    logic run;      // configuration clock may toggle
    logic load;     // take inData into shifter
    logic freeRun;  // toggle clock with no data (post-data phase)
  } ldStrobe_t;
endpackage

// File: rtl/cfgld_dpath.sv
module cfgld_dpath
  import cfgld_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ldStrobe_t        st,
  input  logic             parMode,
  input  logic [DIV_W-1:0] clkHalf,
  input  logic [7:0]       inData,
  input  logic             statusIn,
  input  logic             doneIn,
  output logic             statusS,
  output logic             doneS,
  output logic             empty,
  output logic             rise,
  output logic             tgtClk,
  output logic [7:0]       tgtData
);
  localparam int DW1 = DIV_W + 1;

  logic [1:0]       statSh, doneSh;
  logic [DIV_W-1:0] divCnt, halfLim;
  logic             clkQ, active, halfDone, fall;
  logic [7:0]       sr;
  logic [3:0]       bitsLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statSh <= '0;
      doneSh <= '0;
    end else begin
      statSh <= {statSh[0], statusIn};
      doneSh <= {doneSh[0], doneIn};
    end
  end
  assign statusS = statSh[1];
  assign doneS   = doneSh[1];

  assign halfLim  = (clkHalf == '0) ? DIV_W'(1) : clkHalf;
  assign halfDone = (DW1'(divCnt) + DW1'(1)) >= DW1'(halfLim);
  assign active   = (bitsLeft != 4'd0) || st.freeRun;
  assign rise     = st.run && !clkQ && active && halfDone;
  assign fall     = st.run && clkQ && halfDone;
  assign empty    = (bitsLeft == 4'd0) && !clkQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkQ <= 1'b0; divCnt <= '0; sr <= '0; bitsLeft <= '0;
    end else if (st.clear || !st.run) begin
      clkQ <= 1'b0; divCnt <= '0; sr <= '0; bitsLeft <= '0;
    end else if (st.load) begin
      sr       <= inData;
      bitsLeft <= parMode ? 4'd1 : 4'd8;
      divCnt   <= '0;
    end else if (fall) begin
      clkQ   <= 1'b0;
      divCnt <= '0;
      if (bitsLeft != 4'd0) begin
        bitsLeft <= bitsLeft - 4'd1;
        sr       <= parMode ? 8'd0 : (sr >> 1);
      end
    end else if (rise) begin
      clkQ   <= 1'b1;
      divCnt <= '0;
    end else if (clkQ || active) begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  assign tgtClk  = clkQ;
  assign tgtData = parMode ? sr : {7'd0, sr[0]};

  a_r4_data_steady_high: assert property (@(posedge clk) disable iff (!rstN)
    (clkQ && $past(clkQ)) |-> $stable(tgtData));

  a_r8_stall_clock_low: assert property (@(posedge clk) disable iff (!rstN)
    (st.run && empty && !st.load && !st.freeRun) |=> !clkQ);

  a_r5_high_phase_min: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(clkQ) && clkHalf > DIV_W'(1) && st.run) |-> !halfDone);
endmodule

// File: rtl/cfgld_ctrl.sv
module cfgld_ctrl
  import cfgld_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] reqMin,
  input  logic [CNT_W-1:0] tailMax,
  input  logic             inValid,
  input  logic             inLast,
  input  logic             statusS,
  input  logic             doneS,
  input  logic             empty,
  input  logic             rise,
  output ldStrobe_t        st,
  output logic             inReady,
  output logic             tgtReqN,
  output logic             busy,
  output logic             cfgDone,
  output logic             cfgErr
);
  localparam int CW1 = CNT_W + 1;

  ldState_t         state, nState;
  logic [CNT_W-1:0] cnt;
  logic             sawLow, lastSeen, doneQ, errQ;
  logic             load, finOk, finErr, lowNow;

  assign lowNow = sawLow || !statusS;
  assign load   = (state == S_XFER) && empty && inValid && !lastSeen && statusS;

  always_comb begin
    nState = state;
    finOk  = 1'b0;
    finErr = 1'b0;
    unique case (state)
      S_IDLE, S_FIN: if (start) nState = S_REQ;
      S_REQ: if (lowNow && (CW1'(cnt) + CW1'(1) >= CW1'(reqMin))) nState = S_WAIT;
      S_WAIT: if (statusS) nState = S_XFER;
      S_XFER: begin
        if (!statusS) begin nState = S_FIN; finErr = 1'b1; end
        else if (empty && lastSeen) nState = S_TAIL;
      end
      S_TAIL: begin
        if (!statusS) begin nState = S_FIN; finErr = 1'b1; end
        else if (doneS) begin nState = S_FIN; finOk = 1'b1; end
        else if (cnt >= tailMax) begin nState = S_FIN; finErr = 1'b1; end
      end
      default: nState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; cnt <= '0; sawLow <= 1'b0; lastSeen <= 1'b0;
      doneQ <= 1'b0; errQ <= 1'b0;
    end else begin
      state <= nState;
      if (nState != state) cnt <= '0;
      else if (state == S_REQ || (state == S_TAIL && rise)) cnt <= cnt + CNT_W'(1);
      if ((state == S_IDLE || state == S_FIN) && start) begin
        sawLow <= 1'b0; lastSeen <= 1'b0; doneQ <= 1'b0; errQ <= 1'b0;
      end else begin
        if (state == S_REQ && !statusS) sawLow <= 1'b1;
        if (load && inLast) lastSeen <= 1'b1;
        if (finOk) doneQ <= 1'b1;
        if (finErr) errQ <= 1'b1;
      end
    end
  end

  assign st.clear   = (state == S_IDLE || state == S_FIN) && start;
  assign st.run     = (nState == S_XFER) || (nState == S_TAIL);
  assign st.load    = load;
  assign st.freeRun = (state == S_TAIL);
  assign inReady    = load;
  assign tgtReqN    = (state != S_REQ);
  assign busy       = (state == S_REQ) || (state == S_WAIT) ||
                      (state == S_XFER) || (state == S_TAIL);
  assign cfgDone    = doneQ;
  assign cfgErr     = errQ;

  a_r2_release_after_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tgtReqN) |-> sawLow);

  a_r3_no_edge_before_ready: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_REQ || state == S_WAIT) |-> !rise);

  a_r10_abort_on_status: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_XFER || state == S_TAIL) && !statusS) |=> (cfgErr && !busy));

  a_r9_done_success: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_TAIL && statusS && doneS) |=> (cfgDone && !cfgErr && !busy));

  a_r11_tail_timeout: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_TAIL && statusS && !doneS && cnt >= tailMax) |=> cfgErr);

  a_r12_no_take_after_last: assert property (@(posedge clk) disable iff (!rstN)
    lastSeen |-> !inReady);
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfgld_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             parMode,
  input  logic [DIV_W-1:0] clkHalf,
  input  logic [CNT_W-1:0] reqMin,
  input  logic [CNT_W-1:0] tailMax,
  input  logic [7:0]       inData,
  input  logic             inValid,
  input  logic             inLast,
  output logic             inReady,
  input  logic             tgtStatus,
  input  logic             tgtDoneIn,
  output logic             tgtReqN,
  output logic             tgtClk,
  output logic [7:0]       tgtData,
  output logic             busy,
  output logic             cfgDone,
  output logic             cfgErr
);
  ldStrobe_t st;
  logic statusS, doneS, empty, rise;

  cfgld_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .reqMin(reqMin), .tailMax(tailMax),
    .inValid(inValid), .inLast(inLast), .statusS(statusS), .doneS(doneS),
    .empty(empty), .rise(rise), .st(st), .inReady(inReady), .tgtReqN(tgtReqN),
    .busy(busy), .cfgDone(cfgDone), .cfgErr(cfgErr)
  );

  cfgld_dpath #(.DIV_W(DIV_W)) uDpath (
    .clk(clk), .rstN(rstN), .st(st), .parMode(parMode), .clkHalf(clkHalf),
    .inData(inData), .statusIn(tgtStatus), .doneIn(tgtDoneIn),
    .statusS(statusS), .doneS(doneS), .empty(empty), .rise(rise),
    .tgtClk(tgtClk), .tgtData(tgtData)
  );

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (tgtReqN && !tgtClk && tgtData == 8'd0));
endmodule

// File: tb/sim_cfg_loader.sv
module sim_cfg_loader;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, parMode = 1'b0;
  logic [7:0] clkHalf = 8'd1;
  logic [15:0] reqMin = 16'd4, tailMax = 16'd10;
  logic [7:0] inData = 8'd0;
  logic inValid = 1'b0, inLast = 1'b0;
  logic inReady, tgtReqN, tgtClk, busy, cfgDone, cfgErr;
  logic [7:0] tgtData;
  logic statusLine = 1'b1, doneLine = 1'b0;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic blockLow = 1'b0, forceLow = 1'b0, doneEn = 1'b1;
  int doneAt = 0, abortAt = 0, nCap = 0, takes = 0, reqLowCnt = 0;
  int hiRun = 0, loRun = 0, lastHi = 0, minLo = 1000;
  logic [7:0] cap [0:127];
  logic [7:0] tx [0:15];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_loader u0 (
    .clk(clk), .rstN(rstN), .start(start), .parMode(parMode), .clkHalf(clkHalf),
    .reqMin(reqMin), .tailMax(tailMax), .inData(inData), .inValid(inValid),
    .inLast(inLast), .inReady(inReady), .tgtStatus(statusLine),
    .tgtDoneIn(doneLine), .tgtReqN(tgtReqN), .tgtClk(tgtClk), .tgtData(tgtData),
    .busy(busy), .cfgDone(cfgDone), .cfgErr(cfgErr)
  );

  // target model: status follows request, done after doneAt rising edges
  always @(posedge clk)
    statusLine <= forceLow ? 1'b0 : (!tgtReqN ? blockLow : 1'b1);

  always @(posedge tgtClk) begin
    if (nCap < 128) cap[nCap] = tgtData;
    nCap = nCap + 1;
    if (doneEn && nCap == doneAt) doneLine = 1'b1;
  end

  always @(negedge clk) begin
    if (!tgtReqN) reqLowCnt = reqLowCnt + 1;
    if (tgtClk) begin
      if (loRun > 0 && loRun < minLo) minLo = loRun;
      loRun = 0;
      hiRun = hiRun + 1;
    end else begin
      if (hiRun > 0) lastHi = hiRun;
      hiRun = 0;
      if (busy && !tgtReqN) loRun = 0;
      else if (busy) loRun = loRun + 1;
    end
    if (busy && tgtReqN && !tgtClk && loRun == 0) loRun = 1;
    if (abortAt > 0 && nCap >= abortAt) forceLow = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  task automatic prep();
    nCap = 0; takes = 0; reqLowCnt = 0; lastHi = 0; minLo = 1000;
    loRun = 0; hiRun = 0;
    doneLine = 1'b0; forceLow = 1'b0; abortAt = 0; doneEn = 1'b1;
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // sends n bytes of tx; gap idle cycles after each; stops if sequence ends
  task automatic sendBytes(input int n, input int gap, output int stallHigh);
    stallHigh = 0;
    for (int i = 0; i < n; i++) begin
      inData = tx[i]; inValid = 1'b1; inLast = (i == n-1);
      forever begin
        #1;
        if (!busy) break;
        if (inReady) begin @(negedge clk); takes++; break; end
        @(negedge clk);
      end
      inValid = 1'b0; inLast = 1'b0;
      if (!busy) break;
      for (int g = 0; g < gap; g++) begin
        if (g >= 30 && tgtClk) stallHigh++;
        @(negedge clk);
      end
    end
  endtask

  task automatic waitIdle();
    for (int k = 0; k < 5000 && busy; k++) @(negedge clk);
  endtask

  function automatic int serialMiss(input int n);
    int m = 0;
    for (int i = 0; i < 8*n; i++)
      if (cap[i][0] !== tx[i/8][i%8] || cap[i][7:1] !== 7'd0) m++;
    return m;
  endfunction

  task automatic tReset();
    @(negedge clk);
    chk(tgtReqN && !tgtClk && tgtData == 8'd0, "R1 reset lines", {tgtReqN, tgtClk, tgtData}, 10'h200);
    chk(!busy && !cfgDone && !cfgErr, "R1 reset status", {busy, cfgDone, cfgErr}, 0);
  endtask

  task automatic tSerial();
    int sh;
    prep(); parMode = 1'b0; clkHalf = 8'd2; reqMin = 16'd10; tailMax = 16'd10;
    tx[0] = 8'hA5; tx[1] = 8'h3C; tx[2] = 8'h81;
    doneAt = 26;
    pulseStart();
    sendBytes(3, 0, sh);
    waitIdle();
    chk(reqLowCnt >= 10, "R2 request low length", reqLowCnt, 10);
    chk(serialMiss(3) == 0, "R6 serial bit order", serialMiss(3), 0);
    chk(cfgDone && !cfgErr && !busy, "R9 success", {cfgDone, cfgErr, busy}, 3'b100);
    chk(takes == 3 && !inReady, "R12 bytes taken", takes, 3);
    chk(!tgtClk && tgtData == 8'd0, "R1 lines after end", tgtData, 0);
  endtask

  task automatic tParallel();
    int sh, m;
    prep(); parMode = 1'b1; clkHalf = 8'd1; reqMin = 16'd3; tailMax = 16'd10;
    tx[0] = 8'h12; tx[1] = 8'hFE; tx[2] = 8'h00; tx[3] = 8'h7B;
    doneAt = 5;
    pulseStart();
    sendBytes(4, 0, sh);
    waitIdle();
    m = 0;
    for (int i = 0; i < 4; i++) if (cap[i] !== tx[i]) m++;
    chk(m == 0, "R7 parallel bytes", m, 0);
    chk(cfgDone && !cfgErr, "R9 parallel success", {cfgDone, cfgErr}, 2);
  endtask

  task automatic tStall();
    int sh;
    prep(); parMode = 1'b0; clkHalf = 8'd1; reqMin = 16'd2; tailMax = 16'd10;
    tx[0] = 8'hC3; tx[1] = 8'h5A; tx[2] = 8'hF0;
    doneAt = 24;
    pulseStart();
    sendBytes(3, 60, sh);
    waitIdle();
    chk(sh == 0, "R8 clock low in stall", sh, 0);
    chk(serialMiss(3) == 0, "R8 no bits lost", serialMiss(3), 0);
    chk(nCap >= 24 && nCap <= 34, "R8 edge count", nCap, 24);
  endtask

  task automatic tDivider();
    int sh;
    prep(); parMode = 1'b0; clkHalf = 8'd3; reqMin = 16'd2; tailMax = 16'd10;
    tx[0] = 8'h96; doneAt = 8;
    pulseStart();
    sendBytes(1, 0, sh);
    waitIdle();
    chk(lastHi == 3, "R5 high phase", lastHi, 3);
    chk(minLo >= 3, "R5 low phase", minLo, 3);
    chk(serialMiss(1) == 0, "R4 data captured at rise", serialMiss(1), 0);
  endtask

  task automatic tAbort();
    int sh;
    prep(); parMode = 1'b0; clkHalf = 8'd1; reqMin = 16'd2; tailMax = 16'd10;
    for (int i = 0; i < 4; i++) tx[i] = 8'(i * 37 + 5);
    doneAt = 100; abortAt = 5;
    pulseStart();
    sendBytes(4, 0, sh);
    waitIdle();
    chk(cfgErr && !cfgDone && !busy, "R10 abort flags", {cfgErr, cfgDone, busy}, 3'b100);
    chk(nCap < 32, "R10 stopped early", nCap, 32);
    chk(!tgtClk && tgtData == 8'd0 && tgtReqN, "R10 lines idle", tgtData, 0);
    forceLow = 1'b0; abortAt = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic tTimeout();
    int sh;
    prep(); parMode = 1'b0; clkHalf = 8'd2; reqMin = 16'd2; tailMax = 16'd5;
    doneEn = 1'b0; tx[0] = 8'h4D; doneAt = 0;
    pulseStart();
    sendBytes(1, 0, sh);
    waitIdle();
    chk(cfgErr && !cfgDone, "R11 timeout error", {cfgErr, cfgDone}, 2);
    chk(nCap == 13, "R11 extra edges", nCap, 13);
  endtask

  task automatic tReqHold();
    int sh;
    prep(); parMode = 1'b1; clkHalf = 8'd1; reqMin = 16'd2; tailMax = 16'd10;
    blockLow = 1'b1; tx[0] = 8'hE7; doneAt = 1;
    pulseStart();
    repeat (40) @(negedge clk);
    chk(!tgtReqN && busy, "R2 held until status low", tgtReqN, 0);
    chk(nCap == 0, "R3 no edge before ready", nCap, 0);
    blockLow = 1'b0;
    sendBytes(1, 0, sh);
    waitIdle();
    chk(reqLowCnt >= 40, "R2 long request", reqLowCnt, 40);
    chk(cfgDone && cap[0] == 8'hE7, "R3 load after release", cap[0], 8'hE7);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tSerial();
    tParallel();
    tStall();
    tDivider();
    tAbort();
    tTimeout();
    tReqHold();
    repeat (5) @(negedge clk);
    summary();
  end
endmodule